// File: doc/BRIEF.md
# Multi-channel reloading down-counter timer

A register-mapped timer with two or three independent channels. Each channel holds a 32-bit down-counter, a 32-bit reload value and a 16-bit control word. The control word picks one of five tick rates, which are derived from the peripheral clock by a shared free-running divider. It also carries a sticky underflow flag and an interrupt enable. When a running channel reaches zero on a tick, it reloads from its reload value and raises the flag. Each channel has a level interrupt output.

One shared start register runs or halts every channel. Software uses a channel in one of three ways. For a periodic tick, reload and count hold the same period. For a one-shot, count holds the delay and reload holds the maximum value. For a free-running time base, both hold all-ones, and elapsed ticks are read as the inverse of the count.

The bus is a simple synchronous port with byte address, write data, byte strobes, and read and write enables. Read data appears one clock after the read enable.

Top module: `tick_timer`

## Requirements
- R1: After reset:
  - the start register reads 0;
  - every count and reload register reads 0xFFFFFFFF;
  - every control register reads 0;
  - all interrupt outputs are low.
- R2: Register map:
  - The start register is at byte address 4, with bit n for channel n.
  - Channel n occupies byte addresses 8+12n (reload), 12+12n (count) and 16+12n (control).
  - Read data is valid on the clock after `rd_en_i`.
  - An unmapped address reads 0.
- R3: On a write, byte lane k of the addressed register changes only when `be_i[k]` is 1. The control register uses lanes 0 and 1, and the start register uses lane 0.
- R4: Start bit n at 1 makes channel n count. At 0, the channel's count is held.
- R5: Control bits [2:0] select the tick rate. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks. Ticks come from a free-running divider, so a running channel underflows every (reload+1) × divisor clocks.
- R6: A running channel decrements by one on each selected tick. On a tick where the count is already 0, it loads the reload value instead of wrapping.
- R7: Underflow sets control bit 8. `irq_o[n]` is high while bit 8 and the enable at control bit 5 are both 1.
- R8: Acknowledging the flag:
  - A control write with `be_i[1]`=1 and data bit 8 = 0 clears the flag.
  - Data bit 8 = 1 leaves the flag unchanged.
  - An underflow in the same cycle as a clear wins.
- R9: Prescale codes 5, 6 and 7 stop the counter from advancing.
- R10: A bus write to the count register overrides that cycle's decrement or reload, and no flag is set in that cycle.
- R11: With reload and count both at 0xFFFFFFFF, the bitwise inverse of the count equals the ticks elapsed since start.
- R12: Control bits other than [2:0], 5 and 8 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes for writes |
| wr_en_i | input | 1 | Write enable, one cycle per write |
| rd_en_i | input | 1 | Read enable; data follows one cycle later |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CH | Per-channel level interrupt |

## Verification
The reload-and-underflow function is measured as a period between interrupt edges, over a table of rate codes and reload values. The table covers a reload of 0, where every tick underflows, and several divisors, so it separates a wrong divider stage from an off-by-one in the reload. Free-running mode is checked by reading the inverted count against elapsed clocks. Holding count writes across several ticks tells write priority apart from a lost flag. Reserved rate codes and a cleared start bit must both leave the count unchanged over a span longer than the slowest tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned BE_W         = DATA_W / 8;
  localparam int unsigned CTL_W        = 16;
  localparam int unsigned RATE_CNT     = 5;
  localparam int unsigned PSC_W        = 3;
  localparam int unsigned IE_BIT       = 5;
  localparam int unsigned UF_BIT       = 8;
  localparam int unsigned START_WORD   = 1;
  localparam int unsigned CH_BASE_WORD = 2;
  localparam int unsigned CH_STRIDE    = 3;

  typedef struct packed {
    logic rld;
    logic cnt;
    logic ctl;
  } ch_wr_t;

  function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] wd,
                                                 input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = cur;
    for (int b = 0; b < int'(BE_W); b++)
      if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int unsigned STAGES = RATE_CNT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] tick_o
);
  localparam int unsigned DIV_W = 2 * STAGES;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // stage k pulses once every 4^(k+1) clocks
  for (genvar k = 0; k < int'(STAGES); k++) begin : g_stage
    assign tick_o[k] = &div_q[2*k+1:0];
  end
endmodule

// File: rtl/tick_channel.sv
module tick_channel
  import tick_timer_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [RATE_CNT-1:0] rate_tick_i,
  input  ch_wr_t              wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [BE_W-1:0]     be_i,
  output logic [DATA_W-1:0]   rld_o,
  output logic [DATA_W-1:0]   cnt_o,
  output logic [CTL_W-1:0]    ctl_o,
  output logic                irq_o
);
  logic [DATA_W-1:0] rld_q, cnt_q;
  logic [PSC_W-1:0]  psc_q;
  logic              ie_q, uf_q;
  logic              tick_sel, adv, uflow;

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < int'(RATE_CNT); k++)
      if (psc_q == PSC_W'(k)) tick_sel = rate_tick_i[k];
  end

  assign adv   = run_i & tick_sel & ~wr_i.cnt;
  assign uflow = adv & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '1;
    end else if (wr_i.rld) begin
      rld_q <= merge_be(rld_q, wdata_i, be_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '1;
    else if (wr_i.cnt)  cnt_q <= merge_be(cnt_q, wdata_i, be_i);
    else if (uflow)     cnt_q <= rld_q;
    else if (adv)       cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      ie_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      if (wr_i.ctl && be_i[0]) begin
        psc_q <= wdata_i[PSC_W-1:0];
        ie_q  <= wdata_i[IE_BIT];
      end
      if (uflow)                                        uf_q <= 1'b1;
      else if (wr_i.ctl && be_i[1] && !wdata_i[UF_BIT]) uf_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o            = '0;
    ctl_o[PSC_W-1:0] = psc_q;
    ctl_o[IE_BIT]    = ie_q;
    ctl_o[UF_BIT]    = uf_q;
  end

  assign rld_o = rld_q;
  assign cnt_o = cnt_q;
  assign irq_o = uf_q & ie_q;
endmodule

// File: rtl/tick_regif.sv
module tick_regif
  import tick_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [BE_W-1:0]                be_i,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rld_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_i,
  input  logic [NUM_CH-1:0][CTL_W-1:0]   ctl_i,
  output logic [NUM_CH-1:0]              run_o,
  output ch_wr_t [NUM_CH-1:0]            wr_o,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [NUM_CH-1:0] run_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign word = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      run_q <= '0;
    else if (wr_en_i && be_i[0] && word == WORD_W'(START_WORD))
      run_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_dec
    localparam int unsigned BASE = CH_BASE_WORD + CH_STRIDE * n;
    assign wr_o[n].rld = wr_en_i && (word == WORD_W'(BASE));
    assign wr_o[n].cnt = wr_en_i && (word == WORD_W'(BASE + 1));
    assign wr_o[n].ctl = wr_en_i && (word == WORD_W'(BASE + 2));
  end

  always_comb begin
    rd_mux = '0;
    if (word == WORD_W'(START_WORD)) rd_mux[NUM_CH-1:0] = run_q;
    for (int n = 0; n < int'(NUM_CH); n++) begin
      if (word == WORD_W'(CH_BASE_WORD + CH_STRIDE * n))     rd_mux = rld_i[n];
      if (word == WORD_W'(CH_BASE_WORD + CH_STRIDE * n + 1)) rd_mux = cnt_i[n];
      if (word == WORD_W'(CH_BASE_WORD + CH_STRIDE * n + 2)) rd_mux = {{(DATA_W-CTL_W){1'b0}}, ctl_i[n]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [RATE_CNT-1:0]          rate_tick;
  logic [NUM_CH-1:0]            run_q;
  ch_wr_t [NUM_CH-1:0]          ch_wr;
  logic [NUM_CH-1:0]            cnt_wr;
  logic [NUM_CH-1:0][DATA_W-1:0] rld_arr, cnt_arr;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_arr;

  tick_prescaler #(.STAGES(RATE_CNT)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(rate_tick)
  );

  tick_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .be_i   (be_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .rld_i  (rld_arr),
    .cnt_i  (cnt_arr),
    .ctl_i  (ctl_arr),
    .run_o  (run_q),
    .wr_o   (ch_wr),
    .rdata_o(rdata_o)
  );

  for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch
    assign cnt_wr[n] = ch_wr[n].cnt;
    tick_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q[n]),
      .rate_tick_i(rate_tick),
      .wr_i       (ch_wr[n]),
      .wdata_i    (wdata_i),
      .be_i       (be_i),
      .rld_o      (rld_arr[n]),
      .cnt_o      (cnt_arr[n]),
      .ctl_o      (ctl_arr[n]),
      .irq_o      (irq_o[n])
    );
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_CH-1:0]              run_i,
  input logic [NUM_CH-1:0]              cnt_wr_i,
  input logic [NUM_CH-1:0][DATA_W-1:0]  cnt_i,
  input logic [NUM_CH-1:0][DATA_W-1:0]  rld_i,
  input logic [NUM_CH-1:0][CTL_W-1:0]   ctl_i,
  input logic [RATE_CNT-1:0]            rate_tick_i
);
  function automatic logic sel_tick(input logic [PSC_W-1:0] code,
                                    input logic [RATE_CNT-1:0] t);
    logic r;
    r = 1'b0;
    for (int k = 0; k < int'(RATE_CNT); k++)
      if (code == PSC_W'(k)) r = t[k];
    return r;
  endfunction

  for (genvar k = 1; k < int'(RATE_CNT); k++) begin : g_rate
    // R5: a slower rate only pulses together with every faster one
    a_r5_rate_nesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rate_tick_i[k] |-> rate_tick_i[k-1]);
  end

  for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch
    logic adv;
    assign adv = run_i[n] & sel_tick(ctl_i[n][PSC_W-1:0], rate_tick_i);

    a_r4_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[n] && !cnt_wr_i[n]) |=> $stable(cnt_i[n]));

    a_r6_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !cnt_wr_i[n] && cnt_i[n] != '0) |=> cnt_i[n] == $past(cnt_i[n]) - 1);

    a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !cnt_wr_i[n] && cnt_i[n] == '0) |=> cnt_i[n] == $past(rld_i[n]));

    a_r7_flag_on_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !cnt_wr_i[n] && cnt_i[n] == '0) |=> ctl_i[n][UF_BIT]);

    a_r9_reserved_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i[n][PSC_W-1:0] >= PSC_W'(RATE_CNT) && !cnt_wr_i[n]) |=> $stable(cnt_i[n]));

    a_r10_write_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_wr_i[n] && !ctl_i[n][UF_BIT]) |=> !ctl_i[n][UF_BIT]);
  end
endmodule

bind tick_timer tick_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_q),
  .cnt_wr_i   (cnt_wr),
  .cnt_i      (cnt_arr),
  .rld_i      (rld_arr),
  .ctl_i      (ctl_arr),
  .rate_tick_i(rate_tick)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int NCH = 3;
  localparam int AW  = 6;
  localparam logic [AW-1:0] A_START = 6'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    be = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]   rdata;
  logic [NCH-1:0] irq;

  int checks = 0, errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0]  psc;
    logic [31:0] rld;
    logic [31:0] period;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd0, 32'd2, 32'd12},
    '{3'd0, 32'd0, 32'd4},
    '{3'd1, 32'd1, 32'd32},
    '{3'd2, 32'd0, 32'd64},
    '{3'd0, 32'd5, 32'd24}
  };

  function automatic logic [AW-1:0] ch_a(input int n, input int r);
    return AW'(8 + 12 * n + 4 * r);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input int ch, input int limit, output int at, output bit found);
    found = 1'b0;
    at = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq[ch]) begin
        found = 1'b1;
        at = cyc;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int t0, t1, c0;
    bit ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_START, v);      check("R1 start", v, 32'h0);
    rd(ch_a(0, 1), v);   check("R1 count0", v, 32'hFFFF_FFFF);
    rd(ch_a(2, 0), v);   check("R1 reload2", v, 32'hFFFF_FFFF);
    rd(ch_a(1, 2), v);   check("R1 ctl1", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 map
    wr(ch_a(2, 0), 32'h1234_5678, 4'hF);
    rd(ch_a(2, 0), v);   check("R2 reload2", v, 32'h1234_5678);
    wr(ch_a(1, 1), 32'hCAFE_0001, 4'hF);
    rd(ch_a(1, 1), v);   check("R2 count1", v, 32'hCAFE_0001);
    rd(6'd60, v);        check("R2 unmapped", v, 32'h0);

    // R3 byte lanes, R12 reserved control bits
    wr(ch_a(1, 1), 32'h0000_00AB, 4'b0001);
    rd(ch_a(1, 1), v);   check("R3 byte lane", v, 32'hCAFE_00AB);
    wr(ch_a(1, 2), 32'hFFFF_FEFF, 4'b0001);
    rd(ch_a(1, 2), v);   check("R12 ctl bits", v, 32'h0000_0027);

    // R5/R6 periodic underflow table on channel 0
    for (int i = 0; i < 5; i++) begin
      wr(A_START, 32'h0, 4'h1);
      wr(ch_a(0, 2), 32'h20 | 32'(VEC[i].psc), 4'b0011);
      wr(ch_a(0, 0), VEC[i].rld, 4'hF);
      wr(ch_a(0, 1), VEC[i].rld, 4'hF);
      wr(A_START, 32'h1, 4'h1);
      wait_irq(0, 3000, t0, ok);
      wr(ch_a(0, 2), 32'h20 | 32'(VEC[i].psc), 4'b0011);
      wait_irq(0, 3000, t1, ok);
      check($sformatf("R5 R6 period vec%0d", i), ok ? 32'(t1 - t0) : 32'hDEAD, VEC[i].period);
    end

    // R4 halt holds count
    wr(A_START, 32'h0, 4'h1);
    wr(ch_a(0, 1), 32'h0000_0500, 4'hF);
    rd(ch_a(0, 1), v);
    repeat (1100) @(negedge clk);
    rd(ch_a(0, 1), v2);
    check("R4 halted count", v2, v);
    rd(A_START, v);      check("R2 start read", v, 32'h0);

    // R9 reserved prescale code
    wr(ch_a(1, 2), 32'h0000_0005, 4'b0011);
    wr(ch_a(1, 1), 32'h0000_0100, 4'hF);
    wr(A_START, 32'h2, 4'h1);
    repeat (2100) @(negedge clk);
    rd(ch_a(1, 1), v);   check("R9 reserved code", v, 32'h0000_0100);

    // R7 flag without enable, R8 write-1 keeps, write-0 clears
    wr(ch_a(2, 2), 32'h0000_0000, 4'b0011);
    wr(ch_a(2, 0), 32'h3, 4'hF);
    wr(ch_a(2, 1), 32'h0, 4'hF);
    wr(A_START, 32'h4, 4'h1);
    repeat (20) @(negedge clk);
    check("R7 irq needs enable", 32'(irq[2]), 32'h0);
    rd(ch_a(2, 2), v);   check("R7 flag set", v, 32'h0000_0100);
    wr(A_START, 32'h0, 4'h1);
    wr(ch_a(2, 2), 32'h0000_0120, 4'b0011);
    check("R8 write one keeps flag", 32'(irq[2]), 32'h1);
    wr(ch_a(2, 2), 32'h0000_0020, 4'b0011);
    check("R8 clear irq", 32'(irq[2]), 32'h0);
    rd(ch_a(2, 2), v);   check("R8 clear flag", v, 32'h0000_0020);

    // R10 count write beats underflow
    wr(ch_a(0, 2), 32'h0000_0020, 4'b0011);
    wr(ch_a(0, 0), 32'h5, 4'hF);
    wr(A_START, 32'h1, 4'h1);
    wr(ch_a(0, 2), 32'h0000_0020, 4'b0011);
    for (int i = 0; i < 16; i++) wr(ch_a(0, 1), 32'h0, 4'hF);
    check("R10 no flag under writes", 32'(irq[0]), 32'h0);
    wait_irq(0, 8, t0, ok);
    check("R10 underflow after release", 32'(ok), 32'h1);

    // R11 free-running elapsed ticks
    wr(A_START, 32'h0, 4'h1);
    wr(ch_a(1, 2), 32'h0, 4'b0011);
    wr(ch_a(1, 0), 32'hFFFF_FFFF, 4'hF);
    wr(ch_a(1, 1), 32'hFFFF_FFFF, 4'hF);
    wr(A_START, 32'h2, 4'h1);
    c0 = cyc;
    repeat (400) @(negedge clk);
    rd(ch_a(1, 1), v);
    t1 = (cyc - c0) / 4;
    checks++;
    if (int'(~v) < t1 - 2 || int'(~v) > t1 + 2) begin
      errors++;
      $display("FAIL R11 elapsed actual=%0d expected=%0d+-2", int'(~v), t1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule